// File: doc/BRIEF.md
# Diverse-Encoding Triple-Redundant Datapath

This block computes a small combinational function three times in parallel and votes on the results word by word. Its main purpose is to catch common-mode stuck bits: a stuck bit at the same position in more than one of the replica input registers. A plain triple-redundant copy would corrupt every replica in the same way, and no vote could see it. Here the three input registers are loaded from one shared input word, but each stores a different encoding. The first lane keeps the bits as they are. The second lane stores their inverse. The third lane stores the word rotated by one position. A stuck bit at a common position therefore changes a different logical variable in each lane.

Each replica decodes its own encoding and computes the function outputs together with one or two check outputs. These are parity terms chosen by whether the input width is odd or even. The lane that holds inverted data emits an inverted word, which is turned back before the vote. A word voter passes on the majority word. When all three words differ, it raises an error flag. Six mask inputs force any bit of any register output to 0 or 1, so campaigns of stuck faults can be run against the block.

Top module: `diverse_tmr`

## Requirements
- R1: While reset is asserted and after its release, with no sample taken, `outValid`, `errFlag` and `dataOut` are all 0.
- R2: A sample is presented as `dataIn` with `inValid` high at a rising edge. It is stored at that edge, and its voted result is registered at the next edge. `outValid` is high for exactly one cycle per sample. Back-to-back samples yield back-to-back results in order.
- R3: When no result is captured, `dataOut` and `errFlag` hold their values, whatever `dataIn`, the masks or the stored registers do.
- R4: With `dataIn[0]`=x, `dataIn[1]`=y and `dataIn[2]`=z, a fault-free result is `dataOut[1]` = x·y' + y·z and `dataOut[0]` = x·y' + y·z', with `errFlag` 0.
- R5: Lane 1 stores `dataIn`. Lane 2 stores `~dataIn`. Lane 3 bit i stores `dataIn[(i+1) mod N]`. As a result, forcing bit 0 to 1 in all three lanes with x=0, y=0, z=1 gives three different words, and the error flag is raised.
- R6: A lane's masks act on its register output. A set `forceHi` bit reads as 1, and it wins over `forceLo`. A set `forceLo` bit alone reads as 0. The masks act at the capture edge without a reload.
- R7: When only one lane carries forced bits, the result equals the fault-free result and `errFlag` is 0.
- R8: When all three lane words differ, `errFlag` is 1 and `dataOut` carries the function bits of lane 1.
- R9: For any single bit position and stuck value forced in any two or all three lanes, every result either equals the fault-free result or has `errFlag` set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Load strobe for `dataIn` |
| dataIn | input | N | Shared input word |
| forceLo1 | input | N | Stuck-at-0 mask, lane 1 |
| forceHi1 | input | N | Stuck-at-1 mask, lane 1 |
| forceLo2 | input | N | Stuck-at-0 mask, lane 2 |
| forceHi2 | input | N | Stuck-at-1 mask, lane 2 |
| forceLo3 | input | N | Stuck-at-0 mask, lane 3 |
| forceHi3 | input | N | Stuck-at-1 mask, lane 3 |
| outValid | output | 1 | High for one cycle with each new result |
| dataOut | output | 2 | Voted function outputs (bit 1 first output, bit 0 second) |
| errFlag | output | 1 | No two lane words agreed for this result |

## Verification
Loading a new sample and capturing the vote of the previous one can fall on the same edge. Both lines of work use the lane registers, so an error in the strobe timing would show up as a result computed from the wrong sample. The bench provokes this with `inValid` held high for two cycles in a row. It then expects the two function values in order, one cycle apart, with `outValid` held across both. The stuck-fault sweep covers every position, stuck value, lane pair or triple and input. It judges each result only by the rule "correct, or flagged".

// File: rtl/diverse_tmr_pkg.sv
package diverse_tmr_pkg;

  // How a lane encodes the shared input word in its register.
  typedef enum logic [1:0] {
    FORM_TRUE = 2'd0,
    FORM_INV  = 2'd1,
    FORM_ROT  = 2'd2
  } formT;

  // Strobes from control to datapath.
  typedef struct packed {
    logic load;     // store dataIn into the three lane registers
    logic capture;  // register the voted word and the error flag
  } strobeT;

  localparam int FUNC_W = 2;
  localparam int LANES  = 3;

  // Even widths need one check output, odd widths need two.
  function automatic int checkBits(input int n);
    return ((n % 2) == 0) ? 1 : 2;
  endfunction

  function automatic int wordWidth(input int n);
    return FUNC_W + checkBits(n);
  endfunction

  function automatic formT formOf(input int lane);
    case (lane)
      0:       return FORM_TRUE;
      1:       return FORM_INV;
      default: return FORM_ROT;
    endcase
  endfunction

endpackage

// File: rtl/diverse_tmr_replica.sv
module diverse_tmr_replica
  import diverse_tmr_pkg::*;
#(
  parameter int   N    = 3,
  parameter formT FORM = FORM_TRUE,
  parameter int   W    = wordWidth(N)
) (
  input  logic [N-1:0] regQ,
  output logic [W-1:0] word
);

  // Check parity covers odd vector indices for even N, even indices for odd N.
  localparam int PSEL = ((N % 2) == 0) ? 1 : 0;

  logic [N-1:0] x;
  logic [W-1:0] trueWord;
  logic         f1;
  logic         f2;
  logic         par;

  // Recover the logical variables from the lane encoding.
  if (FORM == FORM_INV) begin : g_decInv
    assign x = ~regQ;
  end else if (FORM == FORM_ROT) begin : g_decRot
    for (genvar j = 0; j < N; j++) begin : g_bit
      assign x[j] = regQ[(j + N - 1) % N];
    end
  end else begin : g_decTrue
    assign x = regQ;
  end

  always_comb begin
    f1  = (x[0] & ~x[1]) | (x[1] &  x[2]);
    f2  = (x[0] & ~x[1]) | (x[1] & ~x[2]);
    par = 1'b0;
    for (int i = 0; i < N; i++) begin
      if ((i % 2) == PSEL) par = par ^ x[i];
    end
  end

  if ((N % 2) == 0) begin : g_evenWord
    assign trueWord = {f1, f2, par};
  end else begin : g_oddWord
    assign trueWord = {f1, f2, par, x[0]};
  end

  // The inverted lane delivers an inverted word, as a dual network would.
  if (FORM == FORM_INV) begin : g_outInv
    assign word = ~trueWord;
  end else begin : g_outTrue
    assign word = trueWord;
  end

endmodule

// File: rtl/diverse_tmr_voter.sv
module diverse_tmr_voter #(
  parameter int W = 4
) (
  input  logic [W-1:0] wordA,
  input  logic [W-1:0] wordB,
  input  logic [W-1:0] wordC,
  output logic [W-1:0] voted,
  output logic         conflict
);

  logic ab;
  logic ac;
  logic bc;

  always_comb begin
    ab = (wordA == wordB);
    ac = (wordA == wordC);
    bc = (wordB == wordC);
    if (ab || ac)  voted = wordA;
    else if (bc)   voted = wordB;
    else           voted = wordA;
    conflict = !(ab || ac || bc);
  end

endmodule

// File: rtl/diverse_tmr_ctrl.sv
module diverse_tmr_ctrl
  import diverse_tmr_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   inValid,
  output strobeT strobe,
  output logic   outValid
);

  logic captureQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      captureQ <= 1'b0;
      outValid <= 1'b0;
    end else begin
      captureQ <= inValid;
      outValid <= captureQ;
    end
  end

  assign strobe.load    = inValid;
  assign strobe.capture = captureQ;

endmodule

// File: rtl/diverse_tmr_datapath.sv
module diverse_tmr_datapath
  import diverse_tmr_pkg::*;
#(
  parameter int N = 3,
  parameter int W = wordWidth(N)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  strobeT                   strobe,
  input  logic [N-1:0]             dataIn,
  input  logic [LANES-1:0][N-1:0]  forceLo,
  input  logic [LANES-1:0][N-1:0]  forceHi,
  output logic [FUNC_W-1:0]        dataOut,
  output logic                     errFlag
);

  logic [W-1:0] voteIn [LANES];
  logic [W-1:0] voted;
  logic         conflict;

  for (genvar r = 0; r < LANES; r++) begin : g_lane
    localparam formT            FORM = formOf(r);
    localparam logic [N-1:0]    RSTV = (FORM == FORM_INV) ? {N{1'b1}} : {N{1'b0}};

    logic [N-1:0] enc;
    logic [N-1:0] stored;
    logic [N-1:0] seen;
    logic [W-1:0] raw;

    if (FORM == FORM_INV) begin : g_encInv
      assign enc = ~dataIn;
    end else if (FORM == FORM_ROT) begin : g_encRot
      for (genvar i = 0; i < N; i++) begin : g_bit
        assign enc[i] = dataIn[(i + 1) % N];
      end
    end else begin : g_encTrue
      assign enc = dataIn;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)            stored <= RSTV;
      else if (strobe.load) stored <= enc;
    end

    // Fault injection on the register output; stuck-at-1 dominates.
    assign seen = (stored & ~forceLo[r]) | forceHi[r];

    diverse_tmr_replica #(.N(N), .FORM(FORM), .W(W)) u_replica (
      .regQ (seen),
      .word (raw)
    );

    if (FORM == FORM_INV) begin : g_reinv
      assign voteIn[r] = ~raw;
    end else begin : g_pass
      assign voteIn[r] = raw;
    end
  end

  diverse_tmr_voter #(.W(W)) u_voter (
    .wordA    (voteIn[0]),
    .wordB    (voteIn[1]),
    .wordC    (voteIn[2]),
    .voted    (voted),
    .conflict (conflict)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataOut <= '0;
      errFlag <= 1'b0;
    end else if (strobe.capture) begin
      dataOut <= voted[W-1 -: FUNC_W];
      errFlag <= conflict;
    end
  end

endmodule

// File: rtl/diverse_tmr.sv
module diverse_tmr
  import diverse_tmr_pkg::*;
#(
  parameter int N = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [N-1:0]      dataIn,
  input  logic [N-1:0]      forceLo1,
  input  logic [N-1:0]      forceHi1,
  input  logic [N-1:0]      forceLo2,
  input  logic [N-1:0]      forceHi2,
  input  logic [N-1:0]      forceLo3,
  input  logic [N-1:0]      forceHi3,
  output logic              outValid,
  output logic [FUNC_W-1:0] dataOut,
  output logic              errFlag
);

  strobeT                  strobe;
  logic [LANES-1:0][N-1:0] loMask;
  logic [LANES-1:0][N-1:0] hiMask;

  assign loMask = {forceLo3, forceLo2, forceLo1};
  assign hiMask = {forceHi3, forceHi2, forceHi1};

  diverse_tmr_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .strobe   (strobe),
    .outValid (outValid)
  );

  diverse_tmr_datapath #(.N(N)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .dataIn  (dataIn),
    .forceLo (loMask),
    .forceHi (hiMask),
    .dataOut (dataOut),
    .errFlag (errFlag)
  );

endmodule

// File: rtl/diverse_tmr_checker.sv
module diverse_tmr_checker #(
  parameter int N = 3
) (
  input logic         clk,
  input logic         rstN,
  input logic         inValid,
  input logic [N-1:0] forceLo1,
  input logic [N-1:0] forceHi1,
  input logic [N-1:0] forceLo2,
  input logic [N-1:0] forceHi2,
  input logic [N-1:0] forceLo3,
  input logic [N-1:0] forceHi3,
  input logic         outValid,
  input logic [1:0]   dataOut,
  input logic         errFlag
);

  logic [2:0] laneHit;
  assign laneHit = {|(forceLo3 | forceHi3), |(forceLo2 | forceHi2), |(forceLo1 | forceHi1)};

  // R2: a stored sample produces outValid two edges later.
  assert_valid_latency_R2: assert property (@(posedge clk) disable iff (!rstN)
    inValid |-> ##2 outValid);

  // R2: no sample, no result pulse.
  assert_no_spurious_valid_R2: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |-> ##2 !outValid);

  // R3: outputs hold when nothing is captured.
  assert_hold_outputs_R3: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> ##1 ($stable(dataOut) && $stable(errFlag)));

  // R7: faults confined to at most one lane never raise the flag.
  assert_single_lane_masked_R7: assert property (@(posedge clk) disable iff (!rstN)
    inValid ##1 ($countones(laneHit) <= 1) |=> !errFlag);

endmodule

bind diverse_tmr diverse_tmr_checker #(.N(N)) u_checker (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .forceLo1 (forceLo1),
  .forceHi1 (forceHi1),
  .forceLo2 (forceLo2),
  .forceHi2 (forceHi2),
  .forceLo3 (forceLo3),
  .forceHi3 (forceHi3),
  .outValid (outValid),
  .dataOut  (dataOut),
  .errFlag  (errFlag)
);

// File: tb/diverse_tmr_test.sv
module diverse_tmr_test;

  localparam int N = 3;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         inValid = 1'b0;
  logic [N-1:0] dataIn = '0;
  logic [N-1:0] lo [3];
  logic [N-1:0] hi [3];
  logic         outValid;
  logic [1:0]   dataOut;
  logic         errFlag;

  int  checks = 0;
  int  errors = 0;
  bit  finished = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  diverse_tmr #(.N(N)) uut (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .dataIn   (dataIn),
    .forceLo1 (lo[0]),
    .forceHi1 (hi[0]),
    .forceLo2 (lo[1]),
    .forceHi2 (hi[1]),
    .forceLo3 (lo[2]),
    .forceHi3 (hi[2]),
    .outValid (outValid),
    .dataOut  (dataOut),
    .errFlag  (errFlag)
  );

  // Expected function per R4: bit0 = x, bit1 = y, bit2 = z.
  function automatic logic [1:0] gold(input logic [2:0] d);
    logic x, y, z;
    x = d[0]; y = d[1]; z = d[2];
    return {(x & ~y) | (y & z), (x & ~y) | (y & ~z)};
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clearMasks();
    for (int r = 0; r < 3; r++) begin
      lo[r] = '0;
      hi[r] = '0;
    end
  endtask

  // One sample: load, capture, then sample outputs after the capture edge.
  task automatic runSample(input logic [N-1:0] d, output logic [1:0] q,
                           output logic e, output logic v);
    @(negedge clk);
    inValid = 1'b1;
    dataIn  = d;
    @(negedge clk);
    inValid = 1'b0;
    @(negedge clk);
    q = dataOut;
    e = errFlag;
    v = outValid;
  endtask

  task automatic testReset();
    check(outValid == 1'b0, "R1 outValid", int'(outValid), 0);
    check(errFlag == 1'b0, "R1 errFlag", int'(errFlag), 0);
    check(dataOut == 2'b00, "R1 dataOut", int'(dataOut), 0);
  endtask

  task automatic testLatency();
    @(negedge clk);
    inValid = 1'b1;
    dataIn  = 3'b001;
    @(negedge clk);
    inValid = 1'b0;
    check(outValid == 1'b0, "R2 no early valid", int'(outValid), 0);
    @(negedge clk);
    check(outValid == 1'b1, "R2 valid one cycle after load", int'(outValid), 1);
    check(dataOut == gold(3'b001), "R2 latency data", int'(dataOut), int'(gold(3'b001)));
    @(negedge clk);
    check(outValid == 1'b0, "R2 single pulse", int'(outValid), 0);
  endtask

  task automatic testBackToBack();
    @(negedge clk);
    inValid = 1'b1;
    dataIn  = 3'b001;   // expect 11
    @(negedge clk);
    dataIn  = 3'b010;   // expect 01
    @(negedge clk);
    inValid = 1'b0;
    check(outValid == 1'b1, "R2 b2b first valid", int'(outValid), 1);
    check(dataOut == gold(3'b001), "R2 b2b first data", int'(dataOut), int'(gold(3'b001)));
    @(negedge clk);
    check(outValid == 1'b1, "R2 b2b second valid", int'(outValid), 1);
    check(dataOut == gold(3'b010), "R2 b2b second data", int'(dataOut), int'(gold(3'b010)));
    @(negedge clk);
    check(outValid == 1'b0, "R2 b2b end", int'(outValid), 0);
  endtask

  task automatic testFunction();
    logic [1:0] q; logic e, v;
    clearMasks();
    for (int d = 0; d < 8; d++) begin
      runSample(N'(d), q, e, v);
      check(q == gold(N'(d)), "R4 function", int'(q), int'(gold(N'(d))));
      check(e == 1'b0, "R4 no flag fault-free", int'(e), 0);
    end
  endtask

  task automatic testHold();
    logic [1:0] q; logic e, v;
    clearMasks();
    runSample(3'b101, q, e, v);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      dataIn = N'(k + 2);
      hi[0]  = N'(k);
      lo[2]  = N'(7 - k);
      check(dataOut == q, "R3 dataOut held", int'(dataOut), int'(q));
      check(errFlag == e, "R3 errFlag held", int'(errFlag), int'(e));
      check(outValid == 1'b0, "R3 no valid while idle", int'(outValid), 0);
    end
    clearMasks();
  endtask

  task automatic testCommonStuck();
    logic [1:0] q; logic e, v;
    clearMasks();
    for (int r = 0; r < 3; r++) hi[r] = 3'b001;
    // x=0,y=0,z=1: lanes see 11, 00, 10 as function bits
    runSample(3'b100, q, e, v);
    check(e == 1'b1, "R5 common bit0 stuck flags", int'(e), 1);
    check(q == 2'b11, "R8 lane1 word on conflict", int'(q), 3);
    clearMasks();
  endtask

  task automatic testInjection();
    logic [1:0] q; logic e, v;
    clearMasks();
    hi[0] = '1; hi[2] = '1; lo[0] = '1; lo[2] = '1;
    runSample(3'b000, q, e, v);
    check(q == gold(3'b111), "R6 stuck-1 wins over stuck-0", int'(q), int'(gold(3'b111)));
    check(e == 1'b0, "R6 agreeing pair no flag", int'(e), 0);
    clearMasks();
    lo[0] = '1; lo[2] = '1;
    runSample(3'b111, q, e, v);
    check(q == gold(3'b000), "R6 stuck-0 reads zero", int'(q), int'(gold(3'b000)));
    // masks applied after the load still act at the capture edge
    clearMasks();
    @(negedge clk);
    inValid = 1'b1;
    dataIn  = 3'b000;
    @(negedge clk);
    inValid = 1'b0;
    hi[0] = '1; hi[2] = '1;
    @(negedge clk);
    check(dataOut == gold(3'b111), "R6 mask acts without reload", int'(dataOut), int'(gold(3'b111)));
    clearMasks();
  endtask

  task automatic testSingleLane();
    logic [1:0] q; logic e, v;
    for (int r = 0; r < 3; r++) begin
      for (int d = 0; d < 8; d++) begin
        clearMasks();
        if ((d % 2) == 0) lo[r] = '1; else hi[r] = 3'b101;
        runSample(N'(d), q, e, v);
        check(q == gold(N'(d)) && e == 1'b0, "R7 single lane masked",
              int'({e, q}), int'({1'b0, gold(N'(d))}));
      end
    end
    clearMasks();
  endtask

  task automatic testSweep();
    logic [1:0] q; logic e, v;
    int sets [4] = '{3'b011, 3'b101, 3'b110, 3'b111};
    for (int p = 0; p < N; p++) begin
      for (int sv = 0; sv < 2; sv++) begin
        for (int s = 0; s < 4; s++) begin
          for (int d = 0; d < 8; d++) begin
            clearMasks();
            for (int r = 0; r < 3; r++) begin
              if (sets[s][r]) begin
                if (sv == 1) hi[r][p] = 1'b1; else lo[r][p] = 1'b1;
              end
            end
            runSample(N'(d), q, e, v);
            check((q == gold(N'(d))) || e, "R9 correct or flagged",
                  int'({e, q}), int'(gold(N'(d))));
          end
        end
      end
    end
    clearMasks();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    clearMasks();
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    testReset();
    testLatency();
    testBackToBack();
    testFunction();
    testHold();
    testCommonStuck();
    testInjection();
    testSingleLane();
    testSweep();
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule